// File: doc/BRIEF.md
# Ten-Source Interrupt Priority Chain Controller

This block arbitrates interrupt requests for a peripheral with two serial channels and four DMA channels, ten sources in all. Each serial channel has three sources: receive, transmit and line-status change. Each DMA channel has one source that is raised by either of two causes, terminal count or abort. The block holds a pending bit and an under-service bit for every source. It raises an active-low request toward the processor and takes part in an external priority chain through a chain-enable input and a chain-enable output. When the processor acknowledges, the block returns an 8-bit vector.

Event pulses set the pending bits. The processor clears pending and under-service bits through two mask inputs that each act for one cycle. The acknowledge strobe `intack` is a level that the processor holds for the whole acknowledge cycle. The block reports the vector with `vec_valid`, which rises one clock after the strobe is first seen high. The vector stays frozen until the strobe falls. The processor applies back-pressure only by holding the strobe, and the vector cannot change while it does.

Top module: `irq_chain_ctl`

## Requirements
- R1: A serial pending bit (`ip_out[5:0]`, bit = channel*3 + kind, kind 0 receive, 1 transmit, 2 status) is set on the clock after its event pulse only when its enable `ser_ie` bit is 1. It is cleared by the matching `ip_clr` bit. A set and a clear in the same cycle leave the bit set.
- R2: Each DMA channel j has a pending bit `ip_out[6+j]`. A terminal-count or abort event sets that bit whatever the enables are. The channel requests only when a cause that has occurred has its own enable (`dma_tc_ie` or `dma_abt_ie`) set. `ip_clr` clears both causes.
- R3: `int_n` is low exactly when `iei` is high and at least one source is eligible. A source is eligible when it is requesting, its group master enable (`ser_mie` or `dma_mie`) is 1, and no under-service bit is set at its own index or any lower index.
- R4: `ieo` is high only when `iei` is high, no under-service bit is set and no source is eligible.
- R5: Priority follows the index, with 0 the highest. Indexes 0–5 are serial A receive, A transmit, A status, B receive, B transmit, B status. Indexes 6–9 are DMA receive A, transmit A, receive B, transmit B.
- R6: On the first clock at which `intack` is sampled high, if `iei` is high and some source is eligible, exactly one under-service bit is set on that clock: the bit of the highest-priority eligible source.
- R7: From the clock after `intack` is first seen high until the clock after it falls, `vec_valid` is high and `vec_out` holds the value latched at the start. That value is `base_vec` when `vec_status_en` is 0. When `vec_status_en` is 1 it is `{base_vec[7:4], winner index}`.
- R8: An under-service bit stays set until its `ius_clr` bit is pulsed. While it is set it blocks that source and all lower-priority sources, and a higher-priority source can still request.
- R9: An acknowledge seen while `iei` is low or while no source is eligible sets no under-service bit and leaves `vec_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_evt | input | 6 | Serial source event pulses |
| ser_ie | input | 6 | Serial source enables |
| ser_mie | input | 1 | Serial group master enable |
| dma_tc_evt | input | 4 | DMA terminal-count event pulses |
| dma_abt_evt | input | 4 | DMA abort event pulses |
| dma_tc_ie | input | 4 | DMA terminal-count enables |
| dma_abt_ie | input | 4 | DMA abort enables |
| dma_mie | input | 1 | DMA group master enable |
| ip_clr | input | 10 | Pending-bit clear mask |
| ius_clr | input | 10 | Under-service clear mask |
| iei | input | 1 | Chain enable in, high means no upstream claim |
| intack | input | 1 | Acknowledge strobe, held for the cycle |
| base_vec | input | 8 | Base vector |
| vec_status_en | input | 1 | Put the winner index into the low vector bits |
| int_n | output | 1 | Active-low interrupt request |
| ieo | output | 1 | Chain enable out |
| vec_valid | output | 1 | Vector valid during acknowledge |
| vec_out | output | 8 | Returned vector |
| ip_out | output | 10 | Pending bits |
| ius_out | output | 10 | Under-service bits |

## Verification
A wrong pending bit shows up on `ip_out` and `int_n` on the clock after the event. A wrong priority mask or a wrong encoder shows up at the next acknowledge, as a wrong index in `vec_out` and a wrong bit in `ius_out`. An under-service bit that is lost or set by mistake changes `ieo` and `int_n` at once, and stays visible until software clears it. Vectors are therefore checked one clock after each acknowledge starts, and the chain outputs are checked immediately after each change to the pending or under-service state.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;
  typedef enum logic [1:0] {
    ACK_IDLE = 2'd0,
    ACK_HIT  = 2'd1,
    ACK_MISS = 2'd2
  } ack_st_t;
endpackage

// File: rtl/irq_ser_bank.sv
module irq_ser_bank #(
  parameter int N_SRC = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] evt,
  input  logic [N_SRC-1:0] ie,
  input  logic [N_SRC-1:0] clr,
  output logic [N_SRC-1:0] ip
);
  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    logic ip_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               ip_q <= 1'b0;
      else if (evt[i] && ie[i]) ip_q <= 1'b1;
      else if (clr[i])          ip_q <= 1'b0;
    end
    assign ip[i] = ip_q;

    // R1: a disabled source never becomes pending
    p_ser_ip_blocked_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!ie[i] && !ip_q) |=> !ip_q);
  end
endmodule

// File: rtl/irq_dma_bank.sv
module irq_dma_bank #(
  parameter int N_CH = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_CH-1:0] tc_evt,
  input  logic [N_CH-1:0] abt_evt,
  input  logic [N_CH-1:0] tc_ie,
  input  logic [N_CH-1:0] abt_ie,
  input  logic [N_CH-1:0] clr,
  output logic [N_CH-1:0] ip,
  output logic [N_CH-1:0] act
);
  for (genvar j = 0; j < N_CH; j++) begin : g_ch
    logic tc_q, abt_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tc_q  <= 1'b0;
        abt_q <= 1'b0;
      end else begin
        if (tc_evt[j])   tc_q <= 1'b1;
        else if (clr[j]) tc_q <= 1'b0;
        if (abt_evt[j])  abt_q <= 1'b1;
        else if (clr[j]) abt_q <= 1'b0;
      end
    end
    assign ip[j]  = tc_q | abt_q;
    assign act[j] = (tc_q & tc_ie[j]) | (abt_q & abt_ie[j]);

    // R2: either cause raises the shared pending bit regardless of enables
    p_dma_ip_ungated_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (tc_evt[j] || abt_evt[j]) |=> ip[j]);
  end
endmodule

// File: rtl/irq_prio.sv
module irq_prio #(
  parameter int N     = 10,
  parameter int IDX_W = 4
) (
  input  logic [N-1:0]     req,
  input  logic [N-1:0]     ius,
  output logic [N-1:0]     elig,
  output logic             any,
  output logic [IDX_W-1:0] win
);
  logic [N-1:0] blk;

  assign blk[0] = ius[0];
  for (genvar k = 1; k < N; k++) begin : g_pfx
    assign blk[k] = blk[k-1] | ius[k];
  end

  assign elig = req & ~blk;
  assign any  = |elig;

  always_comb begin
    win = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (elig[k]) win = IDX_W'(k);
    end
  end
endmodule

// File: rtl/irq_chain_ctl.sv
module irq_chain_ctl
  import irq_chain_pkg::*;
#(
  parameter int N_SER_CH = 2,
  parameter int SER_KIND = 3,
  parameter int N_DMA    = 4,
  parameter int VEC_W    = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [N_SER_CH*SER_KIND-1:0]  ser_evt,
  input  logic [N_SER_CH*SER_KIND-1:0]  ser_ie,
  input  logic                          ser_mie,
  input  logic [N_DMA-1:0]              dma_tc_evt,
  input  logic [N_DMA-1:0]              dma_abt_evt,
  input  logic [N_DMA-1:0]              dma_tc_ie,
  input  logic [N_DMA-1:0]              dma_abt_ie,
  input  logic                          dma_mie,
  input  logic [N_SER_CH*SER_KIND+N_DMA-1:0] ip_clr,
  input  logic [N_SER_CH*SER_KIND+N_DMA-1:0] ius_clr,
  input  logic                          iei,
  input  logic                          intack,
  input  logic [VEC_W-1:0]              base_vec,
  input  logic                          vec_status_en,
  output logic                          int_n,
  output logic                          ieo,
  output logic                          vec_valid,
  output logic [VEC_W-1:0]              vec_out,
  output logic [N_SER_CH*SER_KIND+N_DMA-1:0] ip_out,
  output logic [N_SER_CH*SER_KIND+N_DMA-1:0] ius_out
);
  localparam int N_SER = N_SER_CH * SER_KIND;
  localparam int N     = N_SER + N_DMA;
  localparam int IDX_W = $clog2(N);

  logic [N_SER-1:0] ser_ip;
  logic [N_DMA-1:0] dma_ip, dma_act;
  logic [N-1:0]     req, elig, ius_q, set_mask;
  logic             any_elig;
  logic [IDX_W-1:0] win;
  ack_st_t          st_q;
  logic [VEC_W-1:0] vec_q;
  logic             take;

  irq_ser_bank #(.N_SRC(N_SER)) u_ser (
    .clk(clk), .rst_n(rst_n), .evt(ser_evt), .ie(ser_ie),
    .clr(ip_clr[N_SER-1:0]), .ip(ser_ip)
  );

  irq_dma_bank #(.N_CH(N_DMA)) u_dma (
    .clk(clk), .rst_n(rst_n), .tc_evt(dma_tc_evt), .abt_evt(dma_abt_evt),
    .tc_ie(dma_tc_ie), .abt_ie(dma_abt_ie), .clr(ip_clr[N-1:N_SER]),
    .ip(dma_ip), .act(dma_act)
  );

  assign req = {dma_act & {N_DMA{dma_mie}}, ser_ip & {N_SER{ser_mie}}};

  irq_prio #(.N(N), .IDX_W(IDX_W)) u_prio (
    .req(req), .ius(ius_q), .elig(elig), .any(any_elig), .win(win)
  );

  assign take     = (st_q == ACK_IDLE) && intack && iei && any_elig;
  assign set_mask = take ? (N'(1) << win) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ius_q <= '0;
      st_q  <= ACK_IDLE;
      vec_q <= '0;
    end else begin
      ius_q <= (ius_q & ~ius_clr) | set_mask;
      case (st_q)
        ACK_IDLE: if (intack) begin
          st_q <= take ? ACK_HIT : ACK_MISS;
          if (take)
            vec_q <= vec_status_en ? {base_vec[VEC_W-1:IDX_W], win} : base_vec;
        end
        default:  if (!intack) st_q <= ACK_IDLE;
      endcase
    end
  end

  assign int_n     = ~(iei & any_elig);
  assign ieo       = iei & ~(|ius_q) & ~any_elig;
  assign vec_valid = (st_q == ACK_HIT);
  assign vec_out   = vec_q;
  assign ip_out    = {dma_ip, ser_ip};
  assign ius_out   = ius_q;

  // R3: no request without the upstream chain enable
  p_int_needs_iei_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !iei |-> int_n);
  // R4: a source under service holds the chain output low
  p_ieo_blocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|ius_q) |-> !ieo);
  // R6: at most one under-service bit is added per acknowledge
  p_one_ius_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ACK_IDLE) |=> $onehot0(ius_q & ~$past(ius_q)));
  // R7: the returned vector is frozen while the strobe is held
  p_vec_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && intack) |=> $stable(vec_out));
  // R8: under-service bits persist until explicitly cleared
  p_ius_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ius_q & ~ius_clr)) |=>
      ((ius_q & $past(ius_q & ~ius_clr)) == $past(ius_q & ~ius_clr)));
endmodule

// File: tb/irq_chain_ctl_tb.sv
module irq_chain_ctl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] ser_evt = '0, ser_ie = '1;
  logic       ser_mie = 1'b1, dma_mie = 1'b1;
  logic [3:0] dma_tc_evt = '0, dma_abt_evt = '0, dma_tc_ie = '1, dma_abt_ie = '1;
  logic [9:0] ip_clr = '0, ius_clr = '0;
  logic       iei = 1'b1, intack = 1'b0, vec_status_en = 1'b1;
  logic [7:0] base_vec = 8'hA0;
  logic       int_n, ieo, vec_valid;
  logic [7:0] vec_out;
  logic [9:0] ip_out, ius_out;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_chain_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .ser_evt(ser_evt), .ser_ie(ser_ie), .ser_mie(ser_mie),
    .dma_tc_evt(dma_tc_evt), .dma_abt_evt(dma_abt_evt), .dma_tc_ie(dma_tc_ie),
    .dma_abt_ie(dma_abt_ie), .dma_mie(dma_mie), .ip_clr(ip_clr), .ius_clr(ius_clr),
    .iei(iei), .intack(intack), .base_vec(base_vec), .vec_status_en(vec_status_en),
    .int_n(int_n), .ieo(ieo), .vec_valid(vec_valid), .vec_out(vec_out),
    .ip_out(ip_out), .ius_out(ius_out)
  );

  // {pending pattern (bit = source index), expected winner index}
  localparam logic [13:0] TBL [12] = '{
    {10'b0000000001, 4'd0}, {10'b1111111110, 4'd1}, {10'b1111111100, 4'd2},
    {10'b1111111000, 4'd3}, {10'b1111110000, 4'd4}, {10'b1111100000, 4'd5},
    {10'b1111000000, 4'd6}, {10'b1110000000, 4'd7}, {10'b1100000000, 4'd8},
    {10'b1000000000, 4'd9}, {10'b1000100000, 4'd5}, {10'b0101000000, 4'd6}
  };

  task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic evt(logic [5:0] s, logic [3:0] tc, logic [3:0] ab);
    ser_evt = s; dma_tc_evt = tc; dma_abt_evt = ab;
    tick();
    ser_evt = '0; dma_tc_evt = '0; dma_abt_evt = '0;
  endtask

  task automatic clear_all();
    ip_clr = '1; ius_clr = '1;
    tick();
    ip_clr = '0; ius_clr = '0;
  endtask

  task automatic ack_on();
    intack = 1'b1;
    tick();
  endtask

  task automatic ack_off();
    intack = 1'b0;
    tick();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    // reset state
    chk("R3 reset int_n", int_n, 1);
    chk("R4 reset ieo", ieo, 1);
    chk("R1 reset ip", ip_out, 0);
    chk("R8 reset ius", ius_out, 0);
    chk("R7 reset vec_valid", vec_valid, 0);
    rst_n = 1'b1;
    tick();

    // R5 / R6 / R7 priority table
    for (int i = 0; i < 12; i++) begin
      logic [9:0] pat;
      logic [3:0] w;
      pat = TBL[i][13:4];
      w   = TBL[i][3:0];
      evt(pat[5:0], pat[9:6], 4'b0);
      chk("R1 R2 pending", ip_out, pat);
      chk("R3 request", int_n, 0);
      chk("R4 ieo while requesting", ieo, 0);
      ack_on();
      chk("R7 vec_valid", vec_valid, 1);
      chk("R5 R7 vector", vec_out, {4'hA, w});
      chk("R6 ius winner", ius_out, 10'(1) << w);
      chk("R4 ieo in service", ieo, 0);
      ack_off();
      chk("R7 vec_valid drop", vec_valid, 0);
      chk("R8 ius held", ius_out, 10'(1) << w);
      clear_all();
    end

    // R1: disabled serial source is not latched; set beats clear
    ser_ie[0] = 1'b0;
    evt(6'b000001, 4'b0, 4'b0);
    chk("R1 disabled no ip", ip_out, 0);
    chk("R1 disabled no int", int_n, 1);
    ser_ie[0] = 1'b1;
    ip_clr = 10'b1; ser_evt = 6'b000001;
    tick();
    ip_clr = '0; ser_evt = '0;
    chk("R1 set wins over clear", ip_out, 10'b1);
    clear_all();

    // R2: DMA pending ungated, request gated by cause enables
    dma_tc_ie = '0; dma_abt_ie = '0;
    evt(6'b0, 4'b0001, 4'b0);
    chk("R2 dma ip ungated", ip_out, 10'b0001000000);
    chk("R2 no req when disabled", int_n, 1);
    chk("R4 ieo idle", ieo, 1);
    dma_abt_ie[0] = 1'b1;
    tick();
    chk("R2 other cause enable no req", int_n, 1);
    dma_tc_ie[0] = 1'b1;
    tick();
    chk("R2 matching enable req", int_n, 0);
    clear_all();
    dma_tc_ie = '0;
    evt(6'b0, 4'b0, 4'b0010);
    chk("R2 abort ip", ip_out, 10'b0010000000);
    chk("R2 abort no req", int_n, 1);
    dma_abt_ie[1] = 1'b1;
    tick();
    chk("R2 abort req", int_n, 0);
    dma_tc_ie = '1; dma_abt_ie = '1;
    clear_all();

    // R3: master enables and chain input
    evt(6'b000100, 4'b0, 4'b0);
    ser_mie = 1'b0;
    tick();
    chk("R3 serial mie off", int_n, 1);
    ser_mie = 1'b1;
    iei = 1'b0;
    tick();
    chk("R3 iei low", int_n, 1);
    chk("R4 iei low ieo", ieo, 0);
    // R9: acknowledge with iei low
    ack_on();
    chk("R9 no vec iei low", vec_valid, 0);
    chk("R9 no ius iei low", ius_out, 0);
    ack_off();
    iei = 1'b1;
    clear_all();
    dma_mie = 1'b0;
    evt(6'b0, 4'b1000, 4'b0);
    chk("R3 dma mie off", int_n, 1);
    dma_mie = 1'b1;
    clear_all();
    ack_on();
    chk("R9 no vec nothing pending", vec_valid, 0);
    chk("R9 no ius nothing pending", ius_out, 0);
    ack_off();

    // R7: vector frozen, and unmodified when status-in-vector is off
    evt(6'b010000, 4'b0, 4'b0);
    ack_on();
    base_vec = 8'h3C;
    tick();
    chk("R7 vec stable", vec_out, 8'hA4);
    ack_off();
    clear_all();
    vec_status_en = 1'b0;
    evt(6'b0, 4'b0100, 4'b0);
    ack_on();
    chk("R7 plain vector", vec_out, 8'h3C);
    ack_off();
    vec_status_en = 1'b1; base_vec = 8'hA0;
    clear_all();

    // R8: nesting and explicit clear
    evt(6'b001000, 4'b0, 4'b0);
    ack_on(); ack_off();
    chk("R8 ius3", ius_out, 10'b0000001000);
    evt(6'b100000, 4'b0, 4'b0);
    chk("R8 lower blocked", int_n, 1);
    chk("R4 ieo blocked", ieo, 0);
    evt(6'b000010, 4'b0, 4'b0);
    chk("R8 higher may nest", int_n, 0);
    ack_on();
    chk("R8 nested vector", vec_out, 8'hA1);
    ack_off();
    chk("R8 both in service", ius_out, 10'b0000001010);
    ip_clr = 10'b10; ius_clr = 10'b10;
    tick();
    ip_clr = '0; ius_clr = '0;
    chk("R8 partial clear", ius_out, 10'b0000001000);
    chk("R8 still blocked", int_n, 1);
    ius_clr = 10'b1000;
    tick();
    ius_clr = '0;
    chk("R8 cleared releases", int_n, 0);
    chk("R8 ius empty", ius_out, 0);
    clear_all();
    chk("R4 ieo restored", ieo, 1);

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule